// File: doc/BRIEF.md
# Memory Address and Data Register Port

This block sits between a processor's internal datapath bus and its external memory bus. It holds the address of the current memory access in an address register and the word being moved in a data register. The address register is loaded only from the internal bus, and it drives the external address lines at all times. The data register can be loaded from either bus and can drive either bus, each direction through its own control gate.

The controller starts a read or a write with a one-cycle request. The block then holds the matching memory strobe high and keeps the address steady until memory reports completion. It passes that completion flag back to the controller for exactly one cycle. While an access is pending, the controller may keep using the internal bus. During a read, the data register may be loaded from the internal bus, and the returned word overwrites it in the completion cycle. During a write, the outgoing word is protected from change.

Top module: `memxfer_port`

## Requirements
- R1: After reset, mem_rd, mem_wr, done and busy are low, mem_addr is zero and the data register (visible on mem_wdata) is zero.
- R2: While no access is pending, addr_load stores the low ADDR_W bits of ibus_in into the address register at the clock edge. mem_addr shows that register continuously.
- R3: dreg_drive_int places the data register on ibus_out and raises ibus_out_en in the same cycle. When dreg_drive_int is low, ibus_out is all zeros and ibus_out_en is low.
- R4: rd_req accepted while idle raises mem_rd from the next cycle. mem_rd stays high up to and including the cycle in which mem_done is seen high, and is low in the cycle after. If rd_req and wr_req arrive together, the read is taken and mem_wr stays low.
- R5: wr_req accepted while idle raises mem_wr with the same timing as R4. mem_wdata always shows the data register, and mem_wdata_en equals dreg_drive_ext.
- R6: done is high exactly in the cycles where mem_done is high while an access is pending. A mem_done pulse while idle produces no done and starts nothing.
- R7: The data register takes mem_rdata at the edge ending a cycle in which a read is pending, mem_done is high and dreg_load_ext is high. In that cycle this capture wins over dreg_load_int. At any other time dreg_load_ext has no effect.
- R8: While an access is pending, including its completion cycle, rd_req, wr_req and addr_load are ignored, so mem_addr cannot change during an access.
- R9: dreg_load_int loads ibus_in into the data register while idle or while a read is pending. It is ignored while a write is pending.
- R10: busy is high from the cycle after a request is accepted through the completion cycle, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ibus_in | input | DATA_W | Value present on the internal bus |
| addr_load | input | 1 | Load address register from internal bus |
| dreg_load_int | input | 1 | Load data register from internal bus |
| dreg_load_ext | input | 1 | Load data register from memory data lines on completion of a read |
| dreg_drive_int | input | 1 | Drive data register onto internal bus |
| dreg_drive_ext | input | 1 | Drive data register onto memory data lines |
| rd_req | input | 1 | Start a memory read |
| wr_req | input | 1 | Start a memory write |
| ibus_out | output | DATA_W | Data register onto internal bus, zero when not driven |
| ibus_out_en | output | 1 | Internal bus drive enable |
| mem_addr | output | ADDR_W | Memory address lines |
| mem_rd | output | 1 | Read strobe held for the whole access |
| mem_wr | output | 1 | Write strobe held for the whole access |
| mem_wdata | output | DATA_W | Data register toward memory |
| mem_wdata_en | output | 1 | Memory data drive enable |
| mem_rdata | input | DATA_W | Data returned by memory |
| mem_done | input | 1 | Completion flag from memory |
| done | output | 1 | Completion flag passed to the controller |
| busy | output | 1 | An access is pending |

## Verification
The assertions on strobe holding and single-cycle completion take for granted that memory raises mem_done for one cycle per access and only while a strobe is high. The assertion on read capture takes for granted that mem_rdata is valid in that cycle. The bench memory model counts a fixed latency from the strobe's rise, pulses completion once, and returns data combinationally from the held address. The one deliberate violation, a completion pulse injected while idle, is placed where no strobe is active, so it tests the gating without breaking these assumptions. Controller stimulus changes only at falling edges and keeps each request to one cycle, except where a request during a pending access is the subject of the check.

// File: rtl/memxfer_pkg.sv
package memxfer_pkg;

  typedef enum logic [1:0] {
    XF_IDLE  = 2'd0,
    XF_READ  = 2'd1,
    XF_WRITE = 2'd2
  } xfer_t;

  // Read wins when both requests arrive in the same cycle.
  function automatic xfer_t pick_op(input logic rd, input logic wr);
    if (rd)      return XF_READ;
    else if (wr) return XF_WRITE;
    else         return XF_IDLE;
  endfunction

  function automatic logic is_idle(input xfer_t s);
    return (s == XF_IDLE);
  endfunction

endpackage

// File: rtl/memxfer_addr_reg.sv
module memxfer_addr_reg #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] bus_val,
  output logic [ADDR_W-1:0] addr_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)       addr_q <= '0;
    else if (load_en) addr_q <= bus_val;
  end
endmodule

// File: rtl/memxfer_data_reg.sv
module memxfer_data_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_int,
  input  logic [DATA_W-1:0] int_val,
  input  logic              load_ext,
  input  logic [DATA_W-1:0] ext_val,
  output logic [DATA_W-1:0] data_q
);
  // The returned memory word takes priority over an internal-bus load.
  always_ff @(posedge clk) begin
    if (!rst_n)        data_q <= '0;
    else if (load_ext) data_q <= ext_val;
    else if (load_int) data_q <= int_val;
  end
endmodule

// File: rtl/memxfer_seq.sv
module memxfer_seq
  import memxfer_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  rd_req,
  input  logic  wr_req,
  input  logic  mem_done,
  output xfer_t state,
  output logic  accept,
  output logic  finish
);
  always_comb begin
    accept = is_idle(state) && (rd_req || wr_req);
    finish = !is_idle(state) && mem_done;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      state <= XF_IDLE;
    else if (accept) state <= pick_op(rd_req, wr_req);
    else if (finish) state <= XF_IDLE;
  end
endmodule

// File: rtl/memxfer_port.sv
module memxfer_port
  import memxfer_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] ibus_in,
  input  logic              addr_load,
  input  logic              dreg_load_int,
  input  logic              dreg_load_ext,
  input  logic              dreg_drive_int,
  input  logic              dreg_drive_ext,
  input  logic              rd_req,
  input  logic              wr_req,
  output logic [DATA_W-1:0] ibus_out,
  output logic              ibus_out_en,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_wdata_en,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_done,
  output logic              done,
  output logic              busy
);
  xfer_t             st;
  logic              ev_accept;
  logic              ev_finish;
  logic              ev_mar_wr;
  logic              ev_int_wr;
  logic              ev_ext_wr;
  logic [DATA_W-1:0] mdr_q;

  memxfer_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_req   (rd_req),
    .wr_req   (wr_req),
    .mem_done (mem_done),
    .state    (st),
    .accept   (ev_accept),
    .finish   (ev_finish)
  );

  assign busy      = !is_idle(st);
  assign ev_mar_wr = addr_load && !busy;                              // R8
  assign ev_ext_wr = dreg_load_ext && ev_finish && (st == XF_READ);   // R7
  assign ev_int_wr = dreg_load_int && (st != XF_WRITE);               // R9

  memxfer_addr_reg #(.ADDR_W(ADDR_W)) u_mar (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (ev_mar_wr),
    .bus_val (ibus_in[ADDR_W-1:0]),
    .addr_q  (mem_addr)
  );

  memxfer_data_reg #(.DATA_W(DATA_W)) u_mdr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_int (ev_int_wr),
    .int_val  (ibus_in),
    .load_ext (ev_ext_wr),
    .ext_val  (mem_rdata),
    .data_q   (mdr_q)
  );

  assign mem_rd       = (st == XF_READ);
  assign mem_wr       = (st == XF_WRITE);
  assign done         = ev_finish;
  assign ibus_out     = dreg_drive_int ? mdr_q : '0;
  assign ibus_out_en  = dreg_drive_int;
  assign mem_wdata    = mdr_q;
  assign mem_wdata_en = dreg_drive_ext;
endmodule

// File: rtl/memxfer_port_chk.sv
module memxfer_port_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dreg_load_ext,
  input logic [DATA_W-1:0] ibus_out,
  input logic              ibus_out_en,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic [DATA_W-1:0] mem_rdata,
  input logic              done,
  input logic              busy,
  input logic              ev_accept
);
  assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  assert_rd_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !done) |=> mem_rd);
  assert_wr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && !done) |=> mem_wr);
  assert_addr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |=> $stable(mem_addr));
  assert_done_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (mem_rd || mem_wr));
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !mem_rd && !mem_wr));
  assert_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mem_rd && dreg_load_ext) |=> (mem_wdata == $past(mem_rdata)));
  assert_wdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> $stable(mem_wdata));
  assert_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> (busy && (mem_rd || mem_wr)));
  assert_bus_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ibus_out_en |-> (ibus_out == '0));
endmodule

bind memxfer_port memxfer_port_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .dreg_load_ext (dreg_load_ext),
  .ibus_out      (ibus_out),
  .ibus_out_en   (ibus_out_en),
  .mem_addr      (mem_addr),
  .mem_rd        (mem_rd),
  .mem_wr        (mem_wr),
  .mem_wdata     (mem_wdata),
  .mem_rdata     (mem_rdata),
  .done          (done),
  .busy          (busy),
  .ev_accept     (ev_accept)
);

// File: tb/sim_memxfer_port.sv
module sim_memxfer_port;
  localparam int AW  = 6;
  localparam int DW  = 16;
  localparam int LAT = 3;
  localparam int NW  = 1 << AW;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n;
  logic [DW-1:0] ibus_in;
  logic addr_load, dreg_load_int, dreg_load_ext, dreg_drive_int, dreg_drive_ext;
  logic rd_req, wr_req;
  logic [DW-1:0] ibus_out, mem_wdata, mem_rdata;
  logic          ibus_out_en, mem_rd, mem_wr, mem_wdata_en, mem_done, done, busy;
  logic [AW-1:0] mem_addr;
  logic          mdl_done, inj_done;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  memxfer_port #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .ibus_in(ibus_in), .addr_load(addr_load),
    .dreg_load_int(dreg_load_int), .dreg_load_ext(dreg_load_ext),
    .dreg_drive_int(dreg_drive_int), .dreg_drive_ext(dreg_drive_ext),
    .rd_req(rd_req), .wr_req(wr_req), .ibus_out(ibus_out), .ibus_out_en(ibus_out_en),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .mem_wdata_en(mem_wdata_en), .mem_rdata(mem_rdata), .mem_done(mem_done),
    .done(done), .busy(busy)
  );

  // Behavioural memory: completion LAT cycles after the strobe rises.
  logic [DW-1:0] mem [NW];
  int cnt;
  assign mem_rdata = mem[mem_addr];
  assign mem_done  = mdl_done | inj_done;

  always @(posedge clk) begin
    if (!rst_n) begin
      cnt <= 0;
      mdl_done <= 1'b0;
      for (int i = 0; i < NW; i++) mem[i] <= '0;
    end else begin
      if (!(mem_rd || mem_wr) || mdl_done) begin
        cnt <= 0;
        mdl_done <= 1'b0;
      end else begin
        cnt <= cnt + 1;
        if (cnt + 1 == LAT) mdl_done <= 1'b1;
      end
      if (mdl_done && mem_wr && mem_wdata_en) mem[mem_addr] <= mem_wdata;
    end
  end

  function automatic logic [DW-1:0] pat(input int a);
    return DW'((a * 373) ^ 16'h5A3C ^ (a << 9));
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (!done && n < 40) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic do_write(input int a, input logic [DW-1:0] d);
    int n;
    @(negedge clk);
    ibus_in = d; dreg_load_int = 1;
    @(negedge clk);
    dreg_load_int = 0; ibus_in = DW'(a); addr_load = 1; wr_req = 1; dreg_drive_ext = 1;
    @(negedge clk);
    addr_load = 0; wr_req = 0;
    chk(mem_wr && !mem_rd, "R5 write strobe", {mem_wr, mem_rd}, 2'b10);
    chk(mem_wdata_en == 1'b1, "R5 wdata enable", mem_wdata_en, 1);
    wait_done(n);
    chk(n == LAT, "R6 write completion latency", n, LAT);
    @(negedge clk);
    dreg_drive_ext = 0;
    chk(!mem_wr && !busy, "R4 write strobe falls", {mem_wr, busy}, 0);
  endtask

  task automatic do_read(input int a, output logic [DW-1:0] q);
    int n;
    @(negedge clk);
    ibus_in = DW'(a); addr_load = 1; rd_req = 1; dreg_load_ext = 1;
    @(negedge clk);
    addr_load = 0; rd_req = 0;
    chk(mem_rd && !mem_wr && busy, "R4 R10 read strobe busy", {mem_rd, mem_wr, busy}, 3'b101);
    chk(mem_addr == AW'(a), "R2 address", mem_addr, a);
    wait_done(n);
    chk(n == LAT, "R4 read completion latency", n, LAT);
    @(negedge clk);
    dreg_load_ext = 0;
    chk(!mem_rd && !done && !busy, "R4 R6 R10 after completion", {mem_rd, done, busy}, 0);
    dreg_drive_int = 1;
    #1;
    chk(ibus_out_en == 1'b1, "R3 drive enable", ibus_out_en, 1);
    q = ibus_out;
    @(negedge clk);
    dreg_drive_int = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    finish_run();
  end

  initial begin
    logic [DW-1:0] q;
    int n;
    rst_n = 0; ibus_in = '0; addr_load = 0; dreg_load_int = 0; dreg_load_ext = 0;
    dreg_drive_int = 0; dreg_drive_ext = 0; rd_req = 0; wr_req = 0; inj_done = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk(!mem_rd && !mem_wr && !done && !busy, "R1 strobes", {mem_rd, mem_wr, done, busy}, 0);
    chk(mem_addr == '0, "R1 address", mem_addr, 0);
    chk(mem_wdata == '0, "R1 data register", mem_wdata, 0);
    // R3 undriven bus
    chk(ibus_out == '0 && !ibus_out_en, "R3 bus idle", ibus_out, 0);

    // R2 truncation of the internal bus value into the address register
    ibus_in = 16'hFFC5; addr_load = 1;
    @(negedge clk);
    addr_load = 0;
    chk(mem_addr == 6'h05, "R2 address low bits", mem_addr, 5);

    // Sweep: write every word, then read every word back
    for (int a = 0; a < NW; a++) do_write(a, pat(a));
    for (int a = 0; a < NW; a++) begin
      do_read(a, q);
      chk(q == pat(a), "R7 read-back data", q, pat(a));
    end

    // R6 completion pulse while idle has no effect
    @(negedge clk);
    inj_done = 1;
    #1;
    chk(done == 1'b0, "R6 idle mem_done", done, 0);
    @(negedge clk);
    inj_done = 0;
    chk(!busy && !mem_rd && !mem_wr, "R6 idle mem_done no start", {busy, mem_rd, mem_wr}, 0);

    // R7 dreg_load_ext outside a read completion has no effect
    ibus_in = 16'h0F0F; dreg_load_int = 1;
    @(negedge clk);
    dreg_load_int = 0; dreg_load_ext = 1;
    @(negedge clk);
    dreg_load_ext = 0;
    chk(mem_wdata == 16'h0F0F, "R7 load_ext idle ignored", mem_wdata, 16'h0F0F);

    // R4 simultaneous requests: read wins
    ibus_in = 16'd7; addr_load = 1; rd_req = 1; wr_req = 1;
    @(negedge clk);
    addr_load = 0; rd_req = 0; wr_req = 0;
    chk(mem_rd && !mem_wr, "R4 read priority", {mem_rd, mem_wr}, 2'b10);
    wait_done(n);
    @(negedge clk);

    // R8 R9 R7: requests ignored while busy, internal load during read, capture priority
    ibus_in = 16'd3; addr_load = 1; rd_req = 1; dreg_load_ext = 1;
    @(negedge clk);
    addr_load = 0; rd_req = 0;
    ibus_in = 16'd9; addr_load = 1; wr_req = 1;
    @(negedge clk);
    addr_load = 0; wr_req = 0;
    chk(!mem_wr && mem_rd, "R8 request while busy ignored", {mem_wr, mem_rd}, 2'b01);
    chk(mem_addr == 6'd3, "R8 address held", mem_addr, 3);
    ibus_in = 16'hBEEF; dreg_load_int = 1;
    @(negedge clk);
    dreg_load_int = 0;
    chk(mem_wdata == 16'hBEEF, "R9 internal load during read", mem_wdata, 16'hBEEF);
    wait_done(n);
    ibus_in = 16'h1234; dreg_load_int = 1; rd_req = 1; addr_load = 1;
    @(negedge clk);
    dreg_load_int = 0; rd_req = 0; addr_load = 0; dreg_load_ext = 0;
    chk(mem_wdata == pat(3), "R7 capture wins over internal load", mem_wdata, pat(3));
    chk(!mem_rd && !busy, "R8 request in completion cycle ignored", {mem_rd, busy}, 0);
    chk(mem_addr == 6'd3, "R8 addr_load in completion cycle ignored", mem_addr, 3);

    // R9 internal load ignored while a write is pending
    ibus_in = 16'hAAAA; dreg_load_int = 1;
    @(negedge clk);
    dreg_load_int = 0; ibus_in = 16'd10; addr_load = 1; wr_req = 1; dreg_drive_ext = 1;
    @(negedge clk);
    addr_load = 0; wr_req = 0;
    ibus_in = 16'h5555; dreg_load_int = 1;
    @(negedge clk);
    dreg_load_int = 0;
    chk(mem_wdata == 16'hAAAA, "R9 internal load during write ignored", mem_wdata, 16'hAAAA);
    wait_done(n);
    @(negedge clk);
    dreg_drive_ext = 0;
    do_read(10, q);
    chk(q == 16'hAAAA, "R9 written word intact", q, 16'hAAAA);

    // R3 after drive released
    #1;
    chk(ibus_out == '0 && !ibus_out_en, "R3 bus released", ibus_out, 0);

    finish_run();
  end
endmodule